// File: doc/BRIEF.md
# Clock Source Switch Controller

This block picks the system clock from one of two oscillators: an internal RC oscillator that is always available, and a primary oscillator that needs a start-up period before it can be trusted. A 2-bit source-select input chooses between them. When the primary source is requested, the block switches it on but keeps the system on the RC clock. It waits until a start-up count of primary periods has expired, plus an optional lock wait when the PLL is in use. Only then does it hand the system clock over.

The handover goes through a glitch-free multiplexer. The old clock is gated off while it is low, and only after that is the new clock gated on, also while it is low. Once the primary clock drives the system, a status bit goes high. The RC oscillator is then switched off unless the watchdog or the fail-safe clock monitor still needs it. A request for the RC clock reverses the sequence. If that request arrives while the primary source is still starting, the start-up is abandoned and its counters are cleared.

The start-up counters run on the primary clock. Their result is passed through a two-flop synchronizer into the RC domain, where the control state machine runs. The source-select, watchdog-enable, fail-safe-enable and PLL-use inputs are read-only to the block; it has no path that writes them.

Top module: `clk_source_switch`

## Requirements
- R1: While `srcSel` is binary 11 and any return handover has completed, `sysClk` is the RC clock and `priOscEn` is low.
- R2: Any `srcSel` value other than binary 11 (00, 01 or 10) requests the primary source. `priOscEn` then rises while `sysClk` still runs from the RC clock, and `priActive` stays low until the handover is complete.
- R3: With `pllUse` low, `priActive` rises no earlier than `OST_CYCLES` primary clock periods after `priOscEn` rises, and no more than 30 periods later than that.
- R4: With `pllUse` high, a further `PLL_CYCLES` primary periods are added to the R3 window. `pllEn` is high exactly while `priOscEn` is high and `pllUse` is high.
- R5: When `priActive` is high, `sysClk` runs at the primary clock period and `priOscEn` is high.
- R6: `rcOscEn` is high whenever `wdtEn` or `failSafeEn` is high, whenever `srcSel` is binary 11, and whenever the primary clock is not the active source. While the primary clock is active with all three of those conditions false, `rcOscEn` is low.
- R7: `sysClk` never shows a high or low pulse shorter than the shorter half period of the two input clocks.
- R8: A request for binary 11 while the primary source is still starting aborts the start. `priOscEn` falls and `priActive` never rises. A later primary request waits the full R3 window again, counted from zero.
- R9: While `rstN` is low, `rcOscEn` is 1, `priOscEn` is 0 and `priActive` is 0. After reset is released with `srcSel` at binary 11, `sysClk` runs from the RC clock.
- R10: A request for binary 11 while the primary clock is active clears `priActive` and then drops `priOscEn` once the RC clock drives `sysClk` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| rcClk | input | 1 | Internal RC oscillator clock |
| priClk | input | 1 | Primary oscillator clock, or the PLL output when the PLL is used |
| srcSel | input | 2 | Source select; binary 11 selects the RC clock, any other value selects the primary |
| wdtEn | input | 1 | Watchdog enabled; keeps the RC oscillator on |
| failSafeEn | input | 1 | Fail-safe clock monitor enabled; keeps the RC oscillator on |
| pllUse | input | 1 | Primary path uses the PLL (static while the primary is off) |
| sysClk | output | 1 | Glitch-free system clock |
| priOscEn | output | 1 | Enable for the primary oscillator |
| rcOscEn | output | 1 | Enable for the RC oscillator |
| pllEn | output | 1 | PLL enable |
| priActive | output | 1 | High once the primary clock drives `sysClk` |

## Verification
The switch to the primary clock is tried with every source-select value that requests it (00, 01, 10). Each value is combined with all four watchdog/monitor settings and with the PLL both used and unused. This shows whether the start-up window grows by the lock count only when it should, and whether the RC enable follows the keep-alive inputs rather than the select value. A start that is aborted halfway is followed at once by a fresh request. If the measured window then falls short of the full start-up count, the counters were not cleared. A monitor on every `sysClk` edge measures each pulse width across all handovers, so a runt pulse at any switch is caught.

// File: rtl/clk_switch_pkg.sv
package clk_switch_pkg;

  typedef enum logic [2:0] {
    SW_RC_RUN    = 3'd0,
    SW_PRI_START = 3'd1,
    SW_HANDOVER  = 3'd2,
    SW_PRI_RUN   = 3'd3,
    SW_RETURN    = 3'd4
  } swState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic startPri;
    logic selPri;
  } swStrobe_t;

  // datapath -> control, all valid in the RC clock domain
  typedef struct packed {
    logic readyAtRc;
    logic busyAtRc;
    logic priOnAtRc;
    logic rcOn;
  } swStatus_t;

endpackage

// File: rtl/clk_switch_sync.sv
module clk_switch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/clk_switch_dp.sv
module clk_switch_dp
  import clk_switch_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int PLL_CYCLES  = 80000,
  parameter int SYNC_STAGES = 2
) (
  input  logic      rstN,
  input  logic      rcClk,
  input  logic      priClk,
  input  logic      pllUse,
  input  swStrobe_t strobe,
  output swStatus_t status,
  output logic      sysClk
);
  localparam int OST_W = $clog2(OST_CYCLES + 1);
  localparam int PLL_W = $clog2(PLL_CYCLES + 1);
  localparam logic [OST_W-1:0] OST_LAST = OST_W'(OST_CYCLES);
  localparam logic [PLL_W-1:0] PLL_LAST = PLL_W'(PLL_CYCLES);

  // ---------------- primary-domain start-up qualification ----------------
  logic             startAtPri;
  logic [OST_W-1:0] ostCnt;
  logic [PLL_W-1:0] pllCnt;
  logic             readyPri;
  logic             busyPri;

  clk_switch_sync #(.STAGES(SYNC_STAGES)) u_syncStart (
    .clk(priClk), .rstN(rstN), .dIn(strobe.startPri), .qOut(startAtPri)
  );

  always_ff @(posedge priClk or negedge rstN) begin
    if (!rstN) begin
      ostCnt   <= '0;
      pllCnt   <= '0;
      readyPri <= 1'b0;
    end else if (!startAtPri) begin
      ostCnt   <= '0;
      pllCnt   <= '0;
      readyPri <= 1'b0;
    end else if (ostCnt != OST_LAST) begin
      ostCnt <= ostCnt + 1'b1;
    end else if (pllUse && (pllCnt != PLL_LAST)) begin
      pllCnt <= pllCnt + 1'b1;
    end else begin
      readyPri <= 1'b1;
    end
  end

  always_ff @(posedge priClk or negedge rstN) begin
    if (!rstN) busyPri <= 1'b0;
    else       busyPri <= startAtPri || (ostCnt != '0) || readyPri;
  end

  clk_switch_sync #(.STAGES(SYNC_STAGES)) u_syncReady (
    .clk(rcClk), .rstN(rstN), .dIn(readyPri), .qOut(status.readyAtRc)
  );
  clk_switch_sync #(.STAGES(SYNC_STAGES)) u_syncBusy (
    .clk(rcClk), .rstN(rstN), .dIn(busyPri), .qOut(status.busyAtRc)
  );

  // ---------------- glitch-free clock multiplexer ----------------
  // Each side's enable is retimed on the falling edge of its own clock,
  // so the gate changes only while that clock is low.
  logic [1:0] rcGate;
  logic [1:0] priGate;
  logic       rcOn;
  logic       priOn;

  assign rcOn  = rcGate[1];
  assign priOn = priGate[1];

  always_ff @(negedge rcClk or negedge rstN) begin
    if (!rstN) rcGate <= 2'b11;
    else       rcGate <= {rcGate[0], !strobe.selPri && !priOn};
  end

  always_ff @(negedge priClk or negedge rstN) begin
    if (!rstN) priGate <= 2'b00;
    else       priGate <= {priGate[0], strobe.selPri && !rcOn};
  end

  clk_switch_sync #(.STAGES(SYNC_STAGES)) u_syncPriOn (
    .clk(rcClk), .rstN(rstN), .dIn(priOn), .qOut(status.priOnAtRc)
  );

  assign status.rcOn = rcOn;

  always_comb begin
    sysClk = (rcClk & rcOn) | (priClk & priOn);
  end

  // ---------------- assertions ----------------
  AST_GATES_EXCLUSIVE: assert property (@(posedge rcClk) disable iff (!rstN)
    !(rcOn && priOn)) else $error("both clock gates open"); // R7
  AST_GATES_EXCL_PRI: assert property (@(posedge priClk) disable iff (!rstN)
    !(rcOn && priOn)) else $error("both clock gates open (pri)"); // R7
  AST_OST_DONE: assert property (@(posedge priClk) disable iff (!rstN)
    $rose(readyPri) |-> (ostCnt == OST_LAST)) else $error("ready before start-up count"); // R3
  AST_PLL_DONE: assert property (@(posedge priClk) disable iff (!rstN)
    ($rose(readyPri) && pllUse) |-> (pllCnt == PLL_LAST)) else $error("ready before lock wait"); // R4
  AST_READY_NEEDS_START: assert property (@(posedge priClk) disable iff (!rstN)
    readyPri |-> $past(startAtPri)) else $error("ready without start"); // R8
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clk_switch_pkg::*;
(
  input  logic       rstN,
  input  logic       rcClk,
  input  logic [1:0] srcSel,
  input  logic       wdtEn,
  input  logic       failSafeEn,
  input  logic       pllUse,
  input  swStatus_t  status,
  output swStrobe_t  strobe,
  output logic       priOscEn,
  output logic       rcOscEn,
  output logic       pllEn,
  output logic       priActive
);
  swState_t state;
  swState_t stateNext;
  logic     wantRc;

  assign wantRc = (srcSel == 2'b11);

  always_comb begin
    stateNext = state;
    unique case (state)
      SW_RC_RUN:
        if (!wantRc && !status.busyAtRc && !status.readyAtRc) stateNext = SW_PRI_START;
      SW_PRI_START:
        if (wantRc)                stateNext = SW_RC_RUN;
        else if (status.readyAtRc) stateNext = SW_HANDOVER;
      SW_HANDOVER:
        if (status.priOnAtRc) stateNext = SW_PRI_RUN;
      SW_PRI_RUN:
        if (wantRc) stateNext = SW_RETURN;
      SW_RETURN:
        if (status.rcOn) stateNext = SW_RC_RUN;
      default:
        stateNext = SW_RC_RUN;
    endcase
  end

  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) state <= SW_RC_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.startPri = (state != SW_RC_RUN);
    strobe.selPri   = (state == SW_HANDOVER) || (state == SW_PRI_RUN);
    priOscEn        = strobe.startPri;
    priActive       = (state == SW_PRI_RUN);
    pllEn           = priOscEn && pllUse;
    rcOscEn         = !priActive || wdtEn || failSafeEn || wantRc;
  end

  // ---------------- assertions ----------------
  AST_RC_RUN_ON_RC: assert property (@(posedge rcClk) disable iff (!rstN)
    (state == SW_RC_RUN) |-> status.rcOn) else $error("RC state without RC clock"); // R1
  AST_ACTIVE_HAS_PRI: assert property (@(posedge rcClk) disable iff (!rstN)
    priActive |-> (priOscEn && !status.rcOn)) else $error("active without primary"); // R5
  AST_SELECT_AFTER_READY: assert property (@(posedge rcClk) disable iff (!rstN)
    $rose(strobe.selPri) |-> status.readyAtRc) else $error("switch before ready"); // R3
  AST_RC_KEPT: assert property (@(posedge rcClk) disable iff (!rstN)
    (wdtEn || failSafeEn) |-> rcOscEn) else $error("RC disabled while needed"); // R6
  AST_ABORT_START: assert property (@(posedge rcClk) disable iff (!rstN)
    ((state == SW_PRI_START) && wantRc) |=> !priOscEn) else $error("abort not taken"); // R8
  AST_RETURN_CLEARS: assert property (@(posedge rcClk) disable iff (!rstN)
    ((state == SW_PRI_RUN) && wantRc) |=> !priActive) else $error("status kept on return"); // R10
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch
  import clk_switch_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int PLL_CYCLES  = 80000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rstN,
  input  logic       rcClk,
  input  logic       priClk,
  input  logic [1:0] srcSel,
  input  logic       wdtEn,
  input  logic       failSafeEn,
  input  logic       pllUse,
  output logic       sysClk,
  output logic       priOscEn,
  output logic       rcOscEn,
  output logic       pllEn,
  output logic       priActive
);
  swStrobe_t strobe;
  swStatus_t status;

  clk_switch_ctrl u_ctrl (
    .rstN(rstN), .rcClk(rcClk), .srcSel(srcSel), .wdtEn(wdtEn),
    .failSafeEn(failSafeEn), .pllUse(pllUse), .status(status),
    .strobe(strobe), .priOscEn(priOscEn), .rcOscEn(rcOscEn),
    .pllEn(pllEn), .priActive(priActive)
  );

  clk_switch_dp #(
    .OST_CYCLES(OST_CYCLES), .PLL_CYCLES(PLL_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .rstN(rstN), .rcClk(rcClk), .priClk(priClk), .pllUse(pllUse),
    .strobe(strobe), .status(status), .sysClk(sysClk)
  );

  AST_PLL_FOLLOWS: assert property (@(posedge rcClk) disable iff (!rstN)
    pllEn |-> (priOscEn && pllUse)) else $error("PLL enabled without primary"); // R4
endmodule

// File: tb/clk_source_switch_tb.sv
`timescale 1ns/1ps
module clk_source_switch_tb;
  localparam int OST = 32;
  localparam int PLL = 20;
  localparam int SLACK = 30;
  localparam real RC_PER = 5.0;
  localparam real PRI_PER = 7.0;

  logic rstN = 1'b0;
  logic rcClk = 1'b0;
  logic priClk = 1'b0;
  logic [1:0] srcSel = 2'b11;
  logic wdtEn = 1'b0, failSafeEn = 1'b0, pllUse = 1'b0;
  logic sysClk, priOscEn, rcOscEn, pllEn, priActive;

  int testCount = 0;
  int failCount = 0;

  always #(RC_PER/2)  rcClk  = ~rcClk;
  always #(PRI_PER/2) priClk = ~priClk;

  clk_source_switch #(.OST_CYCLES(OST), .PLL_CYCLES(PLL)) u_dut (
    .rstN(rstN), .rcClk(rcClk), .priClk(priClk), .srcSel(srcSel),
    .wdtEn(wdtEn), .failSafeEn(failSafeEn), .pllUse(pllUse),
    .sysClk(sysClk), .priOscEn(priOscEn), .rcOscEn(rcOscEn),
    .pllEn(pllEn), .priActive(priActive)
  );

  // sysClk period and pulse-width monitors
  realtime lastRise = 0, lastEdge = 0;
  real lastPeriod = 0.0;
  int runtPulses = 0;
  always @(posedge sysClk) begin
    lastPeriod = $realtime - lastRise;
    lastRise = $realtime;
  end
  always @(sysClk) begin
    if (rstN && ($realtime - lastEdge) < 2.4) runtPulses++;
    lastEdge = $realtime;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a > b - 0.1) && (a < b + 0.1);
  endfunction

  // drive a new select and count primary edges until handover
  task automatic requestPrimary(input logic [1:0] sel, output int edges);
    @(negedge rcClk);
    srcSel = sel;
    edges = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge priClk); #1;
      if (priOscEn) edges++;
      if (priActive) break;
    end
  endtask

  task automatic returnToRc(input string tag);
    @(negedge rcClk);
    srcSel = 2'b11;
    #1;
    check(rcOscEn === 1'b1, "R6", {tag, " rcOscEn on RC request"}, rcOscEn, 1);
    for (int i = 0; i < 500; i++) begin
      @(posedge rcClk); #1;
      if (!priOscEn) break;
    end
    check(priActive === 1'b0 && priOscEn === 1'b0, "R10", {tag, " return done"},
          priActive + priOscEn, 0);
    repeat (6) @(posedge rcClk);
    #1;
    check(near(lastPeriod, RC_PER), "R1", {tag, " sysClk back on RC"}, lastPeriod, RC_PER);
  endtask

  initial begin
    #10000000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int edges, lo;
    // R9 reset state
    #20;
    check(rcOscEn === 1'b1 && priOscEn === 1'b0 && priActive === 1'b0, "R9",
          "outputs in reset", {rcOscEn, priOscEn, priActive}, 3'b100);
    #30 rstN = 1'b1;
    repeat (6) @(posedge rcClk);
    #1;
    check(near(lastPeriod, RC_PER), "R9", "sysClk after reset", lastPeriod, RC_PER);
    check(priOscEn === 1'b0, "R1", "primary off while 11", priOscEn, 0);

    // sweep: select value x keep-alive inputs x PLL use
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int s = 0; s < 3; s++) begin
          pllUse = p[0];
          wdtEn = k[0];
          failSafeEn = k[1];
          lo = OST + (p != 0 ? PLL : 0);
          fork
            requestPrimary(2'(s), edges);
            begin
              repeat (4) @(posedge rcClk);
              #1;
              check(priOscEn === 1'b1 && priActive === 1'b0 && near(lastPeriod, RC_PER),
                    "R2", "starting while on RC", priActive, 0);
              check(pllEn === (p != 0), "R4", "pllEn during start", pllEn, p);
            end
          join
          if (p == 0)
            check(edges >= lo && edges <= lo + SLACK, "R3", "start-up window", edges, lo);
          else
            check(edges >= lo && edges <= lo + SLACK, "R4", "start-up plus lock", edges, lo);
          repeat (4) @(posedge priClk);
          #1;
          check(priActive === 1'b1 && near(lastPeriod, PRI_PER), "R5",
                "sysClk on primary", lastPeriod, PRI_PER);
          check(rcOscEn === (k != 0), "R6", "rcOscEn while primary", rcOscEn, k != 0);
          returnToRc("sweep");
        end
      end
    end

    // R8 abort halfway, then restart from zero
    pllUse = 1'b0; wdtEn = 1'b0; failSafeEn = 1'b0;
    @(negedge rcClk);
    srcSel = 2'b00;
    repeat (OST / 2) @(posedge priClk);
    @(negedge rcClk);
    srcSel = 2'b11;
    begin
      bit sawActive = 1'b0;
      for (int i = 0; i < 3 * OST; i++) begin
        @(posedge priClk); #1;
        if (priActive) sawActive = 1'b1;
      end
      check(!sawActive && priOscEn === 1'b0, "R8", "aborted start", sawActive, 0);
    end
    requestPrimary(2'b00, edges);
    check(edges >= OST && edges <= OST + SLACK + 10, "R8", "restart full window", edges, OST);
    returnToRc("abort");

    check(runtPulses == 0, "R7", "no runt pulses on sysClk", runtPulses, 0);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule